// File: doc/BRIEF.md
# Temperature Scratchpad with Threshold Alarm

This block holds the result of a temperature conversion together with two user trigger bytes and presents them as a nine-byte read-only scratchpad. A conversion engine delivers a 16-bit two's-complement temperature word (half a degree per LSB) plus two count bytes with a single-cycle done strobe. On that strobe the block captures the data and decides whether the reading lies outside the window set by the high and low trigger bytes. The alarm flag then holds its value until the next strobe.

A host reads the scratchpad one byte per request. An internal byte index steps forward after every read and returns to zero after the last byte, so a plain run of requests walks the bytes in a loop; a start pulse puts the index back at zero at any time. The last byte is a CRC-8 (polynomial x^8+x^5+x^4+1, bits taken least significant first, register cleared before the first bit) over the eight bytes before it. The trigger bytes are ordinary registers written through a load port.

Top module: `temp_scratchpad`

## Requirements
- R1: After reset the temperature word is 0550h, the remainder and per-degree counts hold their parameter values (0Ch and 10h by default), the high and low triggers hold their parameter values (46h and 0Ah by default), the alarm is 0 and the byte index is 0.
- R2: A clock edge with `conv_done` high stores `conv_temp`, `conv_cnt_rem` and `conv_cnt_per`; the temperature low byte reads at index 0, its high byte at index 1, the remainder count at index 6 and the per-degree count at index 7.
- R3: The high trigger reads at index 2 and the low trigger at index 3; a clock edge with `trig_load` high replaces both with `trig_hi_in` and `trig_lo_in`.
- R4: Indices 4 and 5 always read FFh.
- R5: On a conversion strobe the alarm becomes 1 exactly when the temperature with its half-degree bit dropped (arithmetic shift right by one), taken as signed, is greater than the signed high trigger or less than the signed low trigger; a value equal to a trigger does not alarm.
- R6: The alarm changes only on a clock edge with `conv_done` high; loading new triggers leaves it unchanged until the next strobe.
- R7: Index 8 reads the CRC-8 of bytes 0 to 7, fed byte 0 first and each byte least significant bit first.
- R8: Each request returns the byte at the current index and advances the index by one; after index 8 it returns to 0.
- R9: A `rd_start` pulse sets the index to 0; when it coincides with a request, that request returns byte 0 and the index becomes 1.
- R10: `rd_data` and `rd_valid` are registered: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_req` high, and `rd_data` holds the byte read by that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Conversion result strobe, one cycle |
| conv_temp | input | 16 | Temperature word, half a degree per LSB |
| conv_cnt_rem | input | 8 | Remainder count from the conversion |
| conv_cnt_per | input | 8 | Per-degree count from the conversion |
| trig_load | input | 1 | Load both trigger bytes |
| trig_hi_in | input | 8 | New high trigger, signed |
| trig_lo_in | input | 8 | New low trigger, signed |
| rd_start | input | 1 | Return the byte index to 0 |
| rd_req | input | 1 | Read one byte |
| rd_data | output | 8 | Byte returned by the last request |
| rd_valid | output | 1 | `rd_data` carries a fresh byte |
| rd_index | output | 4 | Index the next request will read (absent a start) |
| alarm | output | 1 | Threshold alarm from the last conversion |

## Verification
The alarm is due one edge after the conversion strobe and a read byte one edge after its request; the bench drives every input on a falling edge, so each result is sampled on the falling edge right after the rising edge that produces it. Trigger loads are followed by a sampling of the unchanged alarm before any new strobe, and the scratchpad contents are compared through reads only, never through internal state.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = 9;
  localparam int NDATA    = NBYTES - 1;
  localparam int IDX_W    = $clog2(NBYTES);
  localparam int TEMP_W   = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] sp_byte_t;

  // fixed layout: neighbours decode these positions
  localparam int POS_TLO  = 0;
  localparam int POS_THI  = 1;
  localparam int POS_TRH  = 2;
  localparam int POS_TRL  = 3;
  localparam int POS_RS0  = 4;
  localparam int POS_RS1  = 5;
  localparam int POS_CREM = 6;
  localparam int POS_CPER = 7;
  localparam int POS_CRC  = 8;

  // x^8 + x^5 + x^4 + 1, bit-reversed form for LSB-first shifting
  localparam sp_byte_t CRC_POLY_REV = 8'h8C;

  function automatic sp_byte_t crc_step(input sp_byte_t cur, input logic bit_in);
    logic fb;
    fb = cur[0] ^ bit_in;
    return (cur >> 1) ^ (fb ? CRC_POLY_REV : '0);
  endfunction
endpackage

// File: rtl/sp_capture.sv
module sp_capture
  import sp_pkg::*;
#(
  parameter logic [TEMP_W-1:0] RST_TEMP = 16'h0550,
  parameter sp_byte_t          RST_CREM = 8'h0C,
  parameter sp_byte_t          RST_CPER = 8'h10,
  parameter sp_byte_t          RST_TH   = 8'h46,
  parameter sp_byte_t          RST_TL   = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [TEMP_W-1:0] conv_temp,
  input  sp_byte_t          conv_crem,
  input  sp_byte_t          conv_cper,
  input  logic              trig_load,
  input  sp_byte_t          trig_hi,
  input  sp_byte_t          trig_lo,
  output logic [TEMP_W-1:0] temp_q,
  output sp_byte_t          crem_q,
  output sp_byte_t          cper_q,
  output sp_byte_t          th_q,
  output sp_byte_t          tl_q
);
  logic [TEMP_W-1:0] temp_d;
  sp_byte_t          crem_d, cper_d, th_d, tl_d;

  always_comb begin
    temp_d = temp_q;
    crem_d = crem_q;
    cper_d = cper_q;
    if (conv_done) begin
      temp_d = conv_temp;
      crem_d = conv_crem;
      cper_d = conv_cper;
    end
  end

  always_comb begin
    th_d = th_q;
    tl_d = tl_q;
    if (trig_load) begin
      th_d = trig_hi;
      tl_d = trig_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= RST_TEMP;
      crem_q <= RST_CREM;
      cper_q <= RST_CPER;
    end else if (conv_done) begin
      temp_q <= temp_d;
      crem_q <= crem_d;
      cper_q <= cper_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_q <= RST_TH;
      tl_q <= RST_TL;
    end else if (trig_load) begin
      th_q <= th_d;
      tl_q <= tl_d;
    end
  end
endmodule

// File: rtl/sp_alarm.sv
module sp_alarm
  import sp_pkg::*;
#(
  parameter int TW = TEMP_W,
  parameter int LW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [TW-1:0] conv_temp,
  input  logic [LW-1:0] th,
  input  logic [LW-1:0] tl,
  output logic          alarm
);
  localparam int EXT = TW - LW;

  logic signed [TW-1:0] whole_deg;
  logic signed [TW-1:0] th_ext, tl_ext;
  logic                 above, below;
  logic                 alarm_d;

  always_comb begin
    whole_deg = $signed(conv_temp) >>> 1;
    th_ext    = $signed({{EXT{th[LW-1]}}, th});
    tl_ext    = $signed({{EXT{tl[LW-1]}}, tl});
    above     = whole_deg > th_ext;
    below     = whole_deg < tl_ext;
    alarm_d   = conv_done ? (above | below) : alarm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm <= 1'b0;
    else if (conv_done) alarm <= alarm_d;
  end
endmodule

// File: rtl/sp_crc.sv
module sp_crc
  import sp_pkg::*;
#(
  parameter int NB = NDATA
) (
  input  logic [NB*BYTE_W-1:0] data_bits,
  output sp_byte_t             crc
);
  localparam int NBITS = NB * BYTE_W;

  sp_byte_t stage [0:NBITS];

  assign stage[0] = '0;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign stage[i+1] = crc_step(stage[i], data_bits[i]);
  end

  assign crc = stage[NBITS];
endmodule

// File: rtl/sp_reader.sv
module sp_reader
  import sp_pkg::*;
#(
  parameter int NB = NBYTES,
  parameter int IW = IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NB-1:0][BYTE_W-1:0] bytes,
  input  logic                rd_start,
  input  logic                rd_req,
  output sp_byte_t            rd_data,
  output logic                rd_valid,
  output logic [IW-1:0]       rd_index
);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  logic [IW-1:0] base_idx, idx_d;
  sp_byte_t      data_d;
  logic          idx_en;

  always_comb begin
    base_idx = rd_start ? '0 : rd_index;
    data_d   = rd_data;
    idx_d    = base_idx;
    if (rd_req) begin
      data_d = bytes[base_idx];
      idx_d  = (base_idx == LAST) ? '0 : base_idx + 1'b1;
    end
    idx_en = rd_req | rd_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_index <= '0;
    else if (idx_en) rd_index <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_req;
  end
endmodule

// File: rtl/temp_scratchpad.sv
module temp_scratchpad
  import sp_pkg::*;
#(
  parameter logic [15:0] RST_TEMP = 16'h0550,
  parameter logic [7:0]  RST_CREM = 8'h0C,
  parameter logic [7:0]  RST_CPER = 8'h10,
  parameter logic [7:0]  RST_TH   = 8'h46,
  parameter logic [7:0]  RST_TL   = 8'h0A,
  parameter logic [7:0]  RSV_BYTE = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conv_done,
  input  logic [15:0] conv_temp,
  input  logic [7:0]  conv_cnt_rem,
  input  logic [7:0]  conv_cnt_per,
  input  logic        trig_load,
  input  logic [7:0]  trig_hi_in,
  input  logic [7:0]  trig_lo_in,
  input  logic        rd_start,
  input  logic        rd_req,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic [3:0]  rd_index,
  output logic        alarm
);
  logic [TEMP_W-1:0] temp_q;
  sp_byte_t          crem_q, cper_q, th_q, tl_q, crc_val;
  logic [NBYTES-1:0][BYTE_W-1:0] pad;

  sp_capture #(
    .RST_TEMP(RST_TEMP), .RST_CREM(RST_CREM), .RST_CPER(RST_CPER),
    .RST_TH(RST_TH), .RST_TL(RST_TL)
  ) u_cap (
    .clk(clk), .rst_n(rst_n),
    .conv_done(conv_done), .conv_temp(conv_temp),
    .conv_crem(conv_cnt_rem), .conv_cper(conv_cnt_per),
    .trig_load(trig_load), .trig_hi(trig_hi_in), .trig_lo(trig_lo_in),
    .temp_q(temp_q), .crem_q(crem_q), .cper_q(cper_q),
    .th_q(th_q), .tl_q(tl_q)
  );

  sp_alarm #(.TW(TEMP_W), .LW(BYTE_W)) u_alm (
    .clk(clk), .rst_n(rst_n),
    .conv_done(conv_done), .conv_temp(conv_temp),
    .th(th_q), .tl(tl_q), .alarm(alarm)
  );

  always_comb begin
    pad[POS_TLO]  = temp_q[BYTE_W-1:0];
    pad[POS_THI]  = temp_q[TEMP_W-1:BYTE_W];
    pad[POS_TRH]  = th_q;
    pad[POS_TRL]  = tl_q;
    pad[POS_RS0]  = RSV_BYTE;
    pad[POS_RS1]  = RSV_BYTE;
    pad[POS_CREM] = crem_q;
    pad[POS_CPER] = cper_q;
    pad[POS_CRC]  = crc_val;
  end

  sp_crc #(.NB(NDATA)) u_crc (
    .data_bits(pad[NDATA-1:0]),
    .crc(crc_val)
  );

  sp_reader #(.NB(NBYTES), .IW(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .bytes(pad),
    .rd_start(rd_start), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_index(rd_index)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_done,
  input logic       trig_load,
  input logic       rd_start,
  input logic       rd_req,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic [3:0] rd_index,
  input logic       alarm
);
  p_valid_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_no_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_alarm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(alarm));
  p_index_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_start && rd_index < 4'd8) |=> rd_index == $past(rd_index) + 4'd1);
  p_index_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_start && rd_index == 4'd8) |=> rd_index == 4'd0);
  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !rd_req) |=> rd_index == 4'd0);
  p_start_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && rd_req) |=> rd_index == 4'd1);
  p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_start && (rd_index == 4'd4 || rd_index == 4'd5)) |=> rd_data == 8'hFF);
  p_index_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_index <= 4'd8);
endmodule

bind temp_scratchpad sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .trig_load(trig_load),
  .rd_start(rd_start), .rd_req(rd_req), .rd_data(rd_data),
  .rd_valid(rd_valid), .rd_index(rd_index), .alarm(alarm)
);

// File: tb/sim_temp_scratchpad.sv
`timescale 1ns/1ps
module sim_temp_scratchpad;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] temp;
    logic [7:0]  th;
    logic [7:0]  tl;
    logic        alm;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0032, 8'h19, 8'h0A, 1'b0},  // 25 == TH, no alarm
    '{16'h0032, 8'h18, 8'h0A, 1'b1},  // 25 > 24
    '{16'h0001, 8'h00, 8'h00, 1'b0},  // +0.5 drops to 0
    '{16'hFFFF, 8'h05, 8'h00, 1'b1},  // -0.5 -> -1 < 0
    '{16'hFF92, 8'h00, 8'hC9, 1'b0},  // -55 == TL
    '{16'hFF92, 8'h00, 8'hCA, 1'b1},  // -55 < -54
    '{16'h00FA, 8'h7D, 8'h80, 1'b0},  // 125 == TH
    '{16'hFE00, 8'h7F, 8'h80, 1'b1}   // -256 < -128
  };

  logic clk = 1'b0;
  logic rst_n;
  logic conv_done, trig_load, rd_start, rd_req;
  logic [15:0] conv_temp;
  logic [7:0]  conv_cnt_rem, conv_cnt_per, trig_hi_in, trig_lo_in;
  logic [7:0]  rd_data;
  logic        rd_valid, alarm;
  logic [3:0]  rd_index;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_scratchpad u0 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_temp(conv_temp),
    .conv_cnt_rem(conv_cnt_rem), .conv_cnt_per(conv_cnt_per),
    .trig_load(trig_load), .trig_hi_in(trig_hi_in), .trig_lo_in(trig_lo_in),
    .rd_start(rd_start), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_index(rd_index), .alarm(alarm)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] b [8]);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[k][j];
        c = c >> 1;
        if (fb) c = c ^ 8'h8C;
      end
    return c;
  endfunction

  task automatic do_conv(input logic [15:0] t, input logic [7:0] cr, input logic [7:0] cp);
    @(negedge clk);
    conv_done = 1'b1; conv_temp = t; conv_cnt_rem = cr; conv_cnt_per = cp;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic do_trig(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    trig_load = 1'b1; trig_hi_in = hi; trig_lo_in = lo;
    @(negedge clk);
    trig_load = 1'b0;
  endtask

  task automatic read_one(input logic start, output logic [7:0] d);
    @(negedge clk);
    rd_req = 1'b1; rd_start = start;
    @(negedge clk);
    rd_req = 1'b0; rd_start = 1'b0;
    check({15'd0, rd_valid}, 16'd1, "R10 valid after request");
    d = rd_data;
  endtask

  task automatic check_pad(input logic [7:0] exp [9], input string tag);
    logic [7:0] got;
    for (int i = 0; i < 9; i++) begin
      read_one(i == 0, got);
      check({8'd0, got}, {8'd0, exp[i]}, $sformatf("%s byte %0d", tag, i));
    end
  endtask

  task automatic build_exp(input logic [15:0] t, input logic [7:0] th, input logic [7:0] tl,
                           input logic [7:0] cr, input logic [7:0] cp, output logic [7:0] e [9]);
    logic [7:0] d8 [8];
    d8[0] = t[7:0]; d8[1] = t[15:8]; d8[2] = th; d8[3] = tl;
    d8[4] = 8'hFF;  d8[5] = 8'hFF;   d8[6] = cr; d8[7] = cp;
    for (int i = 0; i < 8; i++) e[i] = d8[i];
    e[8] = ref_crc(d8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp [9];
    logic [7:0] got;
    rst_n = 1'b0; conv_done = 1'b0; trig_load = 1'b0; rd_start = 1'b0; rd_req = 1'b0;
    conv_temp = '0; conv_cnt_rem = '0; conv_cnt_per = '0; trig_hi_in = '0; trig_lo_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({15'd0, alarm}, 16'd0, "R1 alarm at reset");
    check({12'd0, rd_index}, 16'd0, "R1 index at reset");
    check({15'd0, rd_valid}, 16'd0, "R10 no valid without request");
    build_exp(16'h0550, 8'h46, 8'h0A, 8'h0C, 8'h10, exp);
    check_pad(exp, "R1 R4 R7 reset contents");

    // vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] cr;
      cr = 8'(v * 3 + 1);
      do_trig(VECS[v].th, VECS[v].tl);
      do_conv(VECS[v].temp, cr, 8'h10);
      check({15'd0, alarm}, {15'd0, VECS[v].alm}, $sformatf("R5 alarm vector %0d", v));
      build_exp(VECS[v].temp, VECS[v].th, VECS[v].tl, cr, 8'h10, exp);
      check_pad(exp, $sformatf("R2 R3 R7 vector %0d", v));
    end

    // R8 wrap: index is 0 after byte 8, next read without start gives byte 0
    check({12'd0, rd_index}, 16'd0, "R8 index wrapped");
    read_one(1'b0, got);
    check({8'd0, got}, {8'd0, exp[0]}, "R8 read after wrap");
    read_one(1'b0, got);
    check({8'd0, got}, {8'd0, exp[1]}, "R8 second read after wrap");

    // R9 start with request returns byte 0, index becomes 1
    read_one(1'b0, got);
    read_one(1'b1, got);
    check({8'd0, got}, {8'd0, exp[0]}, "R9 start read byte 0");
    check({12'd0, rd_index}, 16'd1, "R9 index after start read");
    // R9 start alone
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    check({12'd0, rd_index}, 16'd0, "R9 start alone");
    check({15'd0, rd_valid}, 16'd0, "R10 no valid on start alone");

    // R6: trigger change does not move the alarm until a conversion
    do_trig(8'h18, 8'h0A);
    do_conv(16'h0032, 8'h05, 8'h10);
    check({15'd0, alarm}, 16'd1, "R6 alarm set");
    do_trig(8'h7F, 8'h80);
    repeat (3) @(negedge clk);
    check({15'd0, alarm}, 16'd1, "R6 alarm held after trigger load");
    read_one(1'b1, got); read_one(1'b0, got); read_one(1'b0, got);
    check({8'd0, got}, 16'h007F, "R3 new high trigger visible");
    do_conv(16'h0032, 8'h05, 8'h10);
    check({15'd0, alarm}, 16'd0, "R6 alarm cleared by next conversion");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule